// File: doc/BRIEF.md
# Single-Level Vectored Interrupt Unit

This block decides, at each instruction boundary of a 32-bit processor, whether an external interrupt request is taken. A request is taken only when a single enable flag is set. There are no priority levels, and any arbitration among devices happens before this unit. When a request is taken, the unit does the following in one clock edge:

- stores the interrupted program counter and a 16-bit cause word;
- clears the enable flag;
- emits a one-cycle acknowledge;
- redirects the program counter to a vector address built from the requesting device's 8-bit code.

The decoded instruction strobes from the core act on the saved state:

- **Return:** puts the saved program counter back and re-enables interrupts in the same edge.
- **Enable and disable:** set or clear the flag.
- **Save:** drives the saved cause word and program counter onto read ports, so they can be copied into general registers.
- **Restore:** loads the saved cause word and program counter from register values.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset the acknowledge and the PC load strobe are low, and the enable flag is clear, so a request at a boundary is not taken until enable is executed.
- R2: A request present at a boundary while the flag is set causes, on the next clock edge, the PC load strobe with the new PC equal to the 8-bit device code placed in bits 11:4, with bits 3:0 and 31:12 zero.
- R3: The acknowledge is high for exactly one cycle per taken request, in the same cycle as the vector load.
- R4: Taking a request stores the current PC as the saved PC and the 16-bit device info as the saved cause word, and clears the enable flag.
- R5: With the flag clear, the request low, or the boundary strobe low, no acknowledge and no vector load occur.
- R6: The return strobe causes, on the next edge, a PC load with the saved PC, and sets the enable flag on that same edge.
- R7: The enable strobe sets the flag and the disable strobe clears it. If both strobes are high, the flag is cleared. The return strobe overrides both and sets the flag.
- R8: While the save strobe is high, the read ports show the saved cause word zero-extended to 32 bits and the saved PC. While it is low, both ports read zero.
- R9: The restore strobe loads the saved cause word from bits 15:0 of the info write input and the saved PC from the PC write input. A return in the same cycle uses the PC that was saved before that edge.
- R10: In a cycle where a request is taken, the return, restore, enable and disable strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| at_boundary | input | 1 | High in the cycle an instruction boundary is reached |
| irq_req | input | 1 | External interrupt request |
| dev_code | input | 8 | Code of the requesting device, forms the vector |
| dev_info | input | 16 | Cause information of the requesting device |
| cur_pc | input | 32 | PC of the instruction that would run next |
| do_ret | input | 1 | Return-from-interrupt strobe |
| do_ien | input | 1 | Enable-interrupts strobe |
| do_idis | input | 1 | Disable-interrupts strobe |
| do_save | input | 1 | Read-out strobe for the saved state |
| do_restore | input | 1 | Write strobe for the saved state |
| wr_info | input | 32 | Register value whose low 16 bits restore the cause word |
| wr_pc | input | 32 | Register value restoring the saved PC |
| irq_ack | output | 1 | One-cycle acknowledge of a taken request |
| pc_load | output | 1 | The core loads pc_next this cycle |
| pc_next | output | 32 | Vector address or returned PC |
| rd_info | output | 32 | Saved cause word, zero-extended, while saving |
| rd_pc | output | 32 | Saved PC while saving |

## Verification
The assertions assume that every input holds one settled value per clock. They also assume that the strobes are single-cycle levels, each judged on the edge at which it is sampled, with no handshake across cycles. The bench drives every input just after the falling edge and draws the strobes independently at random, so overlapping strobes and strobes that coincide with a taken request both occur. Directed steps first walk through reset, enabling, a blocked request and a return before the random phase starts.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Decoded action for one clock, produced by the decision logic.
  typedef struct packed {
    logic take;     // request accepted at this boundary
    logic ret;      // return executes
    logic restore;  // saved state written from registers
    logic ie_set;   // flag becomes 1
    logic ie_clr;   // flag becomes 0
  } irq_ctl_t;
endpackage

// File: rtl/irq_decide.sv
module irq_decide
  import irq_pkg::*;
(
  input  logic     ie_q,
  input  logic     at_boundary,
  input  logic     irq_req,
  input  logic     do_ret,
  input  logic     do_ien,
  input  logic     do_idis,
  input  logic     do_restore,
  output irq_ctl_t ctl
);
  always_comb begin
    ctl.take    = at_boundary & irq_req & ie_q;
    ctl.ret     = do_ret & ~ctl.take;
    ctl.restore = do_restore & ~ctl.take;
    ctl.ie_clr  = ctl.take | (~do_ret & do_idis);
    ctl.ie_set  = ~ctl.take & (do_ret | (do_ien & ~do_idis));
  end
endmodule

// File: rtl/irq_state.sv
module irq_state
  import irq_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int INFO_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  irq_ctl_t          ctl,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [INFO_W-1:0] dev_info,
  input  logic [PC_W-1:0]   wr_pc,
  input  logic [INFO_W-1:0] wr_info_lo,
  output logic              ie_q,
  output logic [PC_W-1:0]   ipc_q,
  output logic [INFO_W-1:0] ii_q
);
  logic              ie_d, ie_en;
  logic [PC_W-1:0]   ipc_d;
  logic [INFO_W-1:0] ii_d;
  logic              sv_en;

  always_comb begin
    ie_en = ctl.ie_set | ctl.ie_clr;
    ie_d  = ctl.ie_set;
    sv_en = ctl.take | ctl.restore;
    ipc_d = ctl.take ? cur_pc   : wr_pc;
    ii_d  = ctl.take ? dev_info : wr_info_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0;
    end else if (ie_en) begin
      ie_q <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipc_q <= '0;
      ii_q  <= '0;
    end else if (sv_en) begin
      ipc_q <= ipc_d;
      ii_q  <= ii_d;
    end
  end
endmodule

// File: rtl/irq_redirect.sv
module irq_redirect
  import irq_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int CODE_W    = 8,
  parameter int VEC_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  irq_ctl_t          ctl,
  input  logic [CODE_W-1:0] dev_code,
  input  logic [PC_W-1:0]   ipc_q,
  output logic              irq_ack,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_next
);
  localparam int HI_W = PC_W - CODE_W - VEC_SHIFT;

  logic [PC_W-1:0] vec_addr;
  logic [PC_W-1:0] pc_d;
  logic            load_d;

  generate
    if (VEC_SHIFT > 0) begin : g_shift
      assign vec_addr = {{HI_W{1'b0}}, dev_code, {VEC_SHIFT{1'b0}}};
    end else begin : g_flat
      assign vec_addr = {{HI_W{1'b0}}, dev_code};
    end
  endgenerate

  always_comb begin
    load_d = ctl.take | ctl.ret;
    pc_d   = ctl.take ? vec_addr : ipc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_ack <= 1'b0;
      pc_load <= 1'b0;
    end else begin
      irq_ack <= ctl.take;
      pc_load <= load_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_next <= '0;
    end else if (load_d) begin
      pc_next <= pc_d;
    end
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int CODE_W    = 8,
  parameter int INFO_W    = 16,
  parameter int VEC_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              at_boundary,
  input  logic              irq_req,
  input  logic [CODE_W-1:0] dev_code,
  input  logic [INFO_W-1:0] dev_info,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic              do_ret,
  input  logic              do_ien,
  input  logic              do_idis,
  input  logic              do_save,
  input  logic              do_restore,
  input  logic [PC_W-1:0]   wr_info,
  input  logic [PC_W-1:0]   wr_pc,
  output logic              irq_ack,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_next,
  output logic [PC_W-1:0]   rd_info,
  output logic [PC_W-1:0]   rd_pc
);
  localparam int PAD_W = PC_W - INFO_W;

  irq_ctl_t          ctl;
  logic              ie_q;
  logic [PC_W-1:0]   ipc_q;
  logic [INFO_W-1:0] ii_q;

  irq_decide u_decide (
    .ie_q        (ie_q),
    .at_boundary (at_boundary),
    .irq_req     (irq_req),
    .do_ret      (do_ret),
    .do_ien      (do_ien),
    .do_idis     (do_idis),
    .do_restore  (do_restore),
    .ctl         (ctl)
  );

  irq_state #(.PC_W(PC_W), .INFO_W(INFO_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .cur_pc     (cur_pc),
    .dev_info   (dev_info),
    .wr_pc      (wr_pc),
    .wr_info_lo (wr_info[INFO_W-1:0]),
    .ie_q       (ie_q),
    .ipc_q      (ipc_q),
    .ii_q       (ii_q)
  );

  irq_redirect #(.PC_W(PC_W), .CODE_W(CODE_W), .VEC_SHIFT(VEC_SHIFT)) u_redirect (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .dev_code (dev_code),
    .ipc_q    (ipc_q),
    .irq_ack  (irq_ack),
    .pc_load  (pc_load),
    .pc_next  (pc_next)
  );

  always_comb begin
    rd_info = do_save ? {{PAD_W{1'b0}}, ii_q} : '0;
    rd_pc   = do_save ? ipc_q : '0;
  end
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk #(
  parameter int PC_W      = 32,
  parameter int CODE_W    = 8,
  parameter int VEC_SHIFT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              at_boundary,
  input logic              irq_req,
  input logic [CODE_W-1:0] dev_code,
  input logic              do_ret,
  input logic              do_save,
  input logic              ie_q,
  input logic [PC_W-1:0]   ipc_q,
  input logic              irq_ack,
  input logic              pc_load,
  input logic [PC_W-1:0]   pc_next,
  input logic [PC_W-1:0]   rd_info,
  input logic [PC_W-1:0]   rd_pc
);
  logic taking;
  assign taking = at_boundary && irq_req && ie_q;

  assert_vector_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    taking |=> pc_load && (pc_next ==
      ({{(PC_W-CODE_W){1'b0}}, $past(dev_code)} << VEC_SHIFT)));

  assert_ack_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  assert_ack_with_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> pc_load);

  assert_entry_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    taking |=> !ie_q);

  assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!taking && !do_ret) |=> !pc_load && !irq_ack);

  assert_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!taking && do_ret) |=> pc_load && ie_q && (pc_next == $past(ipc_q)));

  assert_ports_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !do_save |-> (rd_info == '0) && (rd_pc == '0));
endmodule

bind irq_vector_unit irq_vector_unit_chk #(
  .PC_W(PC_W), .CODE_W(CODE_W), .VEC_SHIFT(VEC_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary), .irq_req(irq_req),
  .dev_code(dev_code), .do_ret(do_ret), .do_save(do_save), .ie_q(ie_q),
  .ipc_q(ipc_q), .irq_ack(irq_ack), .pc_load(pc_load), .pc_next(pc_next),
  .rd_info(rd_info), .rd_pc(rd_pc)
);

// File: tb/irq_vector_unit_tb.sv
`timescale 1ns/1ps
module irq_vector_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        at_boundary, irq_req, do_ret, do_ien, do_idis, do_save, do_restore;
  logic [7:0]  dev_code;
  logic [15:0] dev_info;
  logic [31:0] cur_pc, wr_info, wr_pc;
  logic        irq_ack, pc_load;
  logic [31:0] pc_next, rd_info, rd_pc;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench model of the saved state
  bit          m_ie;
  logic [31:0] m_ipc;
  logic [15:0] m_ii;

  always #2.5 clk = ~clk;

  irq_vector_unit u_dut (
    .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary), .irq_req(irq_req),
    .dev_code(dev_code), .dev_info(dev_info), .cur_pc(cur_pc),
    .do_ret(do_ret), .do_ien(do_ien), .do_idis(do_idis), .do_save(do_save),
    .do_restore(do_restore), .wr_info(wr_info), .wr_pc(wr_pc),
    .irq_ack(irq_ack), .pc_load(pc_load), .pc_next(pc_next),
    .rd_info(rd_info), .rd_pc(rd_pc)
  );

  function automatic logic [31:0] vec_of(input logic [7:0] c);
    return {20'b0, c, 4'b0000};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    at_boundary = 0; irq_req = 0; do_ret = 0; do_ien = 0; do_idis = 0;
    do_save = 0; do_restore = 0; dev_code = '0; dev_info = '0;
    cur_pc = '0; wr_info = '0; wr_pc = '0;
  endtask

  // Inputs are already driven; check read ports, clock, then check outputs.
  task automatic step();
    bit take, ret;
    logic [31:0] exp_pc;
    #0.5;
    check(do_save ? "R8 rd_info" : "R8 rd_info idle", rd_info, do_save ? {16'b0, m_ii} : 32'b0);
    check(do_save ? "R8 rd_pc"   : "R8 rd_pc idle",   rd_pc,   do_save ? m_ipc : 32'b0);
    take = at_boundary && irq_req && m_ie;
    ret  = !take && do_ret;
    exp_pc = take ? vec_of(dev_code) : m_ipc;
    if (take) begin
      m_ipc = cur_pc; m_ii = dev_info; m_ie = 0;       // R4, R10
    end else begin
      if (do_restore) begin m_ipc = wr_pc; m_ii = wr_info[15:0]; end  // R9
      if (do_ret) m_ie = 1;                                           // R6, R7
      else if (do_idis) m_ie = 0;
      else if (do_ien) m_ie = 1;
    end
    @(posedge clk); #0.5;
    check(take ? "R3 ack on entry" : "R5 R3 no ack", {31'b0, irq_ack}, {31'b0, take});
    check("R2 R6 R5 pc_load", {31'b0, pc_load}, {31'b0, take | ret});
    if (take)      check("R2 vector", pc_next, exp_pc);
    else if (ret)  check("R6 R9 return pc", pc_next, exp_pc);
    @(negedge clk);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(2024);
    idle_inputs();
    rst_n = 0;
    m_ie = 0; m_ipc = '0; m_ii = '0;
    repeat (3) @(negedge clk);
    check("R1 ack reset", {31'b0, irq_ack}, 32'd0);
    check("R1 load reset", {31'b0, pc_load}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R1: request right after reset is not taken
    at_boundary = 1; irq_req = 1; dev_code = 8'h5A; cur_pc = 32'h100; step();
    // R7: enable, then entry R2/R4
    idle_inputs(); do_ien = 1; step();
    idle_inputs(); at_boundary = 1; irq_req = 1; dev_code = 8'hFF;
    dev_info = 16'hBEEF; cur_pc = 32'h0000_2468; step();
    // R3: next cycle ack gone; R5 flag clear blocks request
    idle_inputs(); at_boundary = 1; irq_req = 1; dev_code = 8'h01; step();
    // R8 read-out of saved state
    idle_inputs(); do_save = 1; step();
    // R9 restore together with return uses old IPC, R6 re-enables
    idle_inputs(); do_restore = 1; wr_pc = 32'hCAFE_0000; wr_info = 32'h1234_5678;
    do_ret = 1; step();
    idle_inputs(); do_save = 1; step();
    // R7 both enable and disable -> cleared; then blocked request
    idle_inputs(); do_ien = 1; do_idis = 1; step();
    idle_inputs(); at_boundary = 1; irq_req = 1; step();
    // R10 entry with strobes set: strobes ignored
    idle_inputs(); do_ien = 1; step();
    idle_inputs(); at_boundary = 1; irq_req = 1; dev_code = 8'h00; cur_pc = 32'hFFFF_FFFC;
    dev_info = 16'h0001; do_ret = 1; do_restore = 1; do_ien = 1; wr_pc = 32'h1; step();
    idle_inputs(); do_save = 1; step();

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      at_boundary = ($urandom % 2) == 0;
      irq_req     = ($urandom % 3) == 0;
      do_ret      = ($urandom % 10) == 0;
      do_ien      = ($urandom % 6) == 0;
      do_idis     = ($urandom % 10) == 0;
      do_save     = ($urandom % 4) == 0;
      do_restore  = ($urandom % 12) == 0;
      dev_code    = 8'($urandom);
      dev_info    = 16'($urandom);
      cur_pc      = $urandom;
      wr_info     = $urandom;
      wr_pc       = $urandom;
      step();
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule